// File: doc/BRIEF.md
# Exception Entry Controller

This block performs exception entry and exception return for a small 32-bit RISC core. The pipeline raises a request on one of two lanes: a normal lane that carries a 3-bit cause index, and a debug lane that carries a breakpoint-or-watchpoint select. Both lanes share the program counter of the faulting instruction. When a request is accepted, the controller saves that program counter in the return-address register of the request's class. It moves the global interrupt enable into that class's saved-enable bit, clears the global enable, and produces a redirect target for instruction fetch one clock later.

Each cause owns a 32-byte slot in a vector table: the target is a base address plus the cause index shifted left by 5. Normal causes use the normal base unless the remap control bit is set, in which case they use the debug base. Debug causes always use the debug base. Two return inputs send the core back to a saved address and restore the global enable from the matching saved-enable bit. Software loads the two bases, the remap bit and the global enable through simple write strobes.

Top module: `trap_entry_ctrl`

## Requirements
- R1: After reset, redirect_valid and redirect_pc are 0. Both return addresses, the global enable, both saved-enable bits and remap_state are 0.
- R2: A normal-lane request with cause 2 (instruction bus error), 4 (data bus error), 5 (divide by zero), 6 (interrupt) or 7 (system call) is accepted on one clock edge. At that edge exc_ret_addr takes req_pc, ie_exc_saved takes the prior global enable, and ie_global clears. brk_ret_addr and ie_brk_saved do not change.
- R3: A debug-lane request is accepted on one clock edge. Its cause is 1 (breakpoint) when dbg_watch is 0 and 3 (watchpoint) when dbg_watch is 1. At that edge brk_ret_addr takes req_pc, ie_brk_saved takes the prior global enable, and ie_global clears. exc_ret_addr and ie_exc_saved do not change.
- R4: In the cycle after an accepted request, redirect_valid is 1 for exactly one cycle. redirect_pc equals the selected base plus the cause index times 32.
- R5: A normal-class request vectors from the debug base when remap_state is 1 and from the normal base when it is 0.
- R6: A debug-class request vectors from the debug base whatever the value of remap_state.
- R7: Each base register keeps only bits [31:8] of base_wdata and treats bits [7:0] as zero. Low written bits therefore never appear in redirect_pc.
- R8: When debug and normal requests arrive in the same cycle, only the debug request is taken. exc_ret_addr and ie_exc_saved stay unchanged.
- R9: A normal-lane request with cause 0, 1 or 3 is ignored. No redirect follows and the enable state and return addresses are unchanged.
- R10: eret restores ie_global from ie_exc_saved and redirects to exc_ret_addr. bret restores ie_global from ie_brk_saved and redirects to brk_ret_addr. Both take effect with the same one-cycle timing as R4. Any accepted exception takes priority over a return, and bret takes priority over eret.
- R11: ie_we loads ie_global from ie_wdata when no exception or return is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_req | input | 1 | Debug-class exception request |
| dbg_watch | input | 1 | 1 selects watchpoint, 0 selects breakpoint |
| norm_req | input | 1 | Normal-class exception request |
| norm_cause | input | 3 | Cause index for the normal lane |
| req_pc | input | 32 | Program counter of the excepting instruction |
| bret | input | 1 | Return from breakpoint |
| eret | input | 1 | Return from exception |
| eba_we | input | 1 | Write strobe for the normal base |
| deba_we | input | 1 | Write strobe for the debug base |
| base_wdata | input | 32 | Write data for either base register |
| remap_we | input | 1 | Write strobe for the remap bit |
| remap_wdata | input | 1 | Remap bit write data |
| ie_we | input | 1 | Write strobe for the global enable |
| ie_wdata | input | 1 | Global enable write data |
| redirect_valid | output | 1 | One-cycle strobe: fetch must load redirect_pc |
| redirect_pc | output | 32 | Vector or return target |
| exc_ret_addr | output | 32 | Saved address of the last normal exception |
| brk_ret_addr | output | 32 | Saved address of the last debug exception |
| ie_global | output | 1 | Global interrupt enable |
| ie_exc_saved | output | 1 | Enable saved by a normal exception |
| ie_brk_saved | output | 1 | Enable saved by a debug exception |
| remap_state | output | 1 | Current remap bit |

## Verification
The assertions assume that base and remap writes are not issued in the same cycle as an accepted exception. If they were, the vector would be built from the old base while the checks compare against the register value. The assertions also assume that req_pc is stable while a request is driven. Every scenario task in the bench keeps the write strobes and the requests in separate cycles. Each task holds a request for exactly one cycle, so every acceptance is a single event that can be attributed to one lane.

// File: rtl/trap_pkg.sv
package trap_pkg;

   typedef enum logic [2:0] {
      CAUSE_RESET = 3'd0,
      CAUSE_BRKPT = 3'd1,
      CAUSE_IBUS  = 3'd2,
      CAUSE_WATCH = 3'd3,
      CAUSE_DBUS  = 3'd4,
      CAUSE_DIVZ  = 3'd5,
      CAUSE_IRQ   = 3'd6,
      CAUSE_SCALL = 3'd7
   } cause_e;

   typedef enum logic [2:0] {
      EV_NONE = 3'd0,
      EV_DBG  = 3'd1,
      EV_NORM = 3'd2,
      EV_BRET = 3'd3,
      EV_ERET = 3'd4
   } event_e;

   localparam int CAUSE_W = 3;

   function automatic logic is_normal_cause(input cause_e c);
      return (c == CAUSE_IBUS) || (c == CAUSE_DBUS) || (c == CAUSE_DIVZ) ||
             (c == CAUSE_IRQ)  || (c == CAUSE_SCALL);
   endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
   import trap_pkg::*;
(
   input  logic         dbg_req,
   input  logic         dbg_watch,
   input  logic         norm_req,
   input  logic [2:0]   norm_cause,
   input  logic         bret,
   input  logic         eret,
   output event_e       ev,
   output cause_e       cause
);

   cause_e norm_c;
   logic   norm_ok;

   assign norm_c  = cause_e'(norm_cause);
   assign norm_ok = norm_req && is_normal_cause(norm_c);

   // Fixed priority: debug, normal, breakpoint return, exception return
   always_comb begin
      ev    = EV_NONE;
      cause = CAUSE_RESET;
      if (dbg_req) begin
         ev    = EV_DBG;
         cause = dbg_watch ? CAUSE_WATCH : CAUSE_BRKPT;
      end else if (norm_ok) begin
         ev    = EV_NORM;
         cause = norm_c;
      end else if (bret) begin
         ev    = EV_BRET;
      end else if (eret) begin
         ev    = EV_ERET;
      end
   end

endmodule

// File: rtl/trap_vector.sv
module trap_vector
   import trap_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int BASE_LSB   = 8,
   parameter int SLOT_SHIFT = 5
) (
   input  logic [XLEN-1:BASE_LSB] eba_hi,
   input  logic [XLEN-1:BASE_LSB] deba_hi,
   input  logic                   remap,
   input  event_e                 ev,
   input  cause_e                 cause,
   input  logic [XLEN-1:0]        ea,
   input  logic [XLEN-1:0]        ba,
   output logic [XLEN-1:0]        target
);

   logic [XLEN-1:BASE_LSB] base_sel;
   logic [XLEN-1:0]        base_full;
   logic [XLEN-1:0]        slot_off;

   assign slot_off  = XLEN'(cause) << SLOT_SHIFT;
   assign base_full = {base_sel, {BASE_LSB{1'b0}}};

   always_comb begin
      base_sel = eba_hi;
      if (ev == EV_DBG || remap) base_sel = deba_hi;
   end

   always_comb begin
      unique case (ev)
         EV_DBG, EV_NORM: target = base_full + slot_off;
         EV_ERET:         target = ea;
         EV_BRET:         target = ba;
         default:         target = '0;
      endcase
   end

endmodule

// File: rtl/trap_state.sv
module trap_state
   import trap_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  event_e          ev,
   input  logic [XLEN-1:0] pc,
   input  logic            ie_we,
   input  logic            ie_wdata,
   output logic [XLEN-1:0] ea,
   output logic [XLEN-1:0] ba,
   output logic            ie,
   output logic            eie,
   output logic            bie
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea  <= '0;
         ba  <= '0;
         ie  <= 1'b0;
         eie <= 1'b0;
         bie <= 1'b0;
      end else begin
         unique case (ev)
            EV_NORM: begin
               ea  <= pc;
               eie <= ie;
               ie  <= 1'b0;
            end
            EV_DBG: begin
               ba  <= pc;
               bie <= ie;
               ie  <= 1'b0;
            end
            EV_ERET: ie <= eie;
            EV_BRET: ie <= bie;
            default: if (ie_we) ie <= ie_wdata;
         endcase
      end
   end

   p_norm_save_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev == EV_NORM |=> !ie && eie == $past(ie) && ea == $past(pc) && $stable(ba) && $stable(bie));

   p_dbg_save_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev == EV_DBG |=> !ie && bie == $past(ie) && ba == $past(pc) && $stable(ea) && $stable(eie));

   p_eret_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ev == EV_ERET |=> ie == $past(eie));

   p_bret_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ev == EV_BRET |=> ie == $past(bie));

   p_ie_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_NONE && ie_we) |=> ie == $past(ie_wdata));

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
   import trap_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int BASE_LSB   = 8,
   parameter int SLOT_SHIFT = 5,
   parameter bit REMAP_EN   = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            dbg_req,
   input  logic            dbg_watch,
   input  logic            norm_req,
   input  logic [2:0]      norm_cause,
   input  logic [XLEN-1:0] req_pc,
   input  logic            bret,
   input  logic            eret,
   input  logic            eba_we,
   input  logic            deba_we,
   input  logic [XLEN-1:0] base_wdata,
   input  logic            remap_we,
   input  logic            remap_wdata,
   input  logic            ie_we,
   input  logic            ie_wdata,
   output logic            redirect_valid,
   output logic [XLEN-1:0] redirect_pc,
   output logic [XLEN-1:0] exc_ret_addr,
   output logic [XLEN-1:0] brk_ret_addr,
   output logic            ie_global,
   output logic            ie_exc_saved,
   output logic            ie_brk_saved,
   output logic            remap_state
);

   localparam int SLOT_TOP = CAUSE_W + SLOT_SHIFT;

   initial begin
      a_width_ok: assert (XLEN > BASE_LSB)
         else $error("XLEN must exceed BASE_LSB");
      a_no_carry: assert (SLOT_TOP <= BASE_LSB)
         else $error("vector slots overlap the base field");
   end

   logic [XLEN-1:BASE_LSB] eba_hi;
   logic [XLEN-1:BASE_LSB] deba_hi;
   logic                   unused_low;
   event_e                 ev;
   cause_e                 cause;
   logic [XLEN-1:0]        target;

   assign unused_low = ^base_wdata[BASE_LSB-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eba_hi  <= '0;
         deba_hi <= '0;
      end else begin
         if (eba_we)  eba_hi  <= base_wdata[XLEN-1:BASE_LSB];
         if (deba_we) deba_hi <= base_wdata[XLEN-1:BASE_LSB];
      end
   end

   generate
      if (REMAP_EN) begin : g_remap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        remap_state <= 1'b0;
            else if (remap_we) remap_state <= remap_wdata;
         end
      end else begin : g_no_remap
         logic unused_remap;
         assign unused_remap = remap_we ^ remap_wdata;
         assign remap_state  = 1'b0;
      end
   endgenerate

   trap_arbiter u_arb (
      .dbg_req    (dbg_req),
      .dbg_watch  (dbg_watch),
      .norm_req   (norm_req),
      .norm_cause (norm_cause),
      .bret       (bret),
      .eret       (eret),
      .ev         (ev),
      .cause      (cause)
   );

   trap_vector #(
      .XLEN       (XLEN),
      .BASE_LSB   (BASE_LSB),
      .SLOT_SHIFT (SLOT_SHIFT)
   ) u_vec (
      .eba_hi  (eba_hi),
      .deba_hi (deba_hi),
      .remap   (remap_state),
      .ev      (ev),
      .cause   (cause),
      .ea      (exc_ret_addr),
      .ba      (brk_ret_addr),
      .target  (target)
   );

   trap_state #(.XLEN(XLEN)) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev),
      .pc       (req_pc),
      .ie_we    (ie_we),
      .ie_wdata (ie_wdata),
      .ea       (exc_ret_addr),
      .ba       (brk_ret_addr),
      .ie       (ie_global),
      .eie      (ie_exc_saved),
      .bie      (ie_brk_saved)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         redirect_valid <= 1'b0;
         redirect_pc    <= '0;
      end else begin
         redirect_valid <= (ev != EV_NONE);
         if (ev != EV_NONE) redirect_pc <= target;
      end
   end

   p_slot_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_DBG || ev == EV_NORM) |=> redirect_valid && redirect_pc[SLOT_SHIFT-1:0] == '0);

   p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev == EV_NONE) |=> !redirect_valid);

   p_dbg_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ev == EV_DBG |=> redirect_pc[XLEN-1:BASE_LSB] == $past(deba_hi));

   p_norm_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ev == EV_NORM |=> redirect_pc[XLEN-1:BASE_LSB] ==
                        ($past(remap_state) ? $past(deba_hi) : $past(eba_hi)));

   p_dbg_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_req && norm_req) |=> $stable(exc_ret_addr) && $stable(ie_exc_saved));

   p_bad_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (norm_req && !dbg_req && !bret && !eret && !ie_we &&
       !is_normal_cause(cause_e'(norm_cause)))
      |=> !redirect_valid && $stable(ie_global) && $stable(exc_ret_addr));

endmodule

// File: tb/trap_entry_ctrl_bench.sv
`timescale 1ns/1ps
module trap_entry_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dbg_req = 0, dbg_watch = 0, norm_req = 0, bret = 0, eret = 0;
   logic [2:0]  norm_cause = '0;
   logic [31:0] req_pc = '0, base_wdata = '0;
   logic        eba_we = 0, deba_we = 0, remap_we = 0, remap_wdata = 0;
   logic        ie_we = 0, ie_wdata = 0;
   logic        redirect_valid, ie_global, ie_exc_saved, ie_brk_saved, remap_state;
   logic [31:0] redirect_pc, exc_ret_addr, brk_ret_addr;

   int n_cmp = 0;
   int n_bad = 0;

   // bench-side model
   logic [31:0] m_eba = 0, m_deba = 0, m_ea = 0, m_ba = 0;
   logic        m_ie = 0, m_eie = 0, m_bie = 0, m_remap = 0;

   always #2.5 clk = ~clk;

   trap_entry_ctrl u_trap_entry_ctrl (
      .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .dbg_watch(dbg_watch),
      .norm_req(norm_req), .norm_cause(norm_cause), .req_pc(req_pc),
      .bret(bret), .eret(eret), .eba_we(eba_we), .deba_we(deba_we),
      .base_wdata(base_wdata), .remap_we(remap_we), .remap_wdata(remap_wdata),
      .ie_we(ie_we), .ie_wdata(ie_wdata), .redirect_valid(redirect_valid),
      .redirect_pc(redirect_pc), .exc_ret_addr(exc_ret_addr),
      .brk_ret_addr(brk_ret_addr), .ie_global(ie_global),
      .ie_exc_saved(ie_exc_saved), .ie_brk_saved(ie_brk_saved),
      .remap_state(remap_state)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_state(input string tag);
      check({tag, " ea"},  exc_ret_addr, m_ea);
      check({tag, " ba"},  brk_ret_addr, m_ba);
      check({tag, " ie"},  32'(ie_global), 32'(m_ie));
      check({tag, " eie"}, 32'(ie_exc_saved), 32'(m_eie));
      check({tag, " bie"}, 32'(ie_brk_saved), 32'(m_bie));
   endtask

   function automatic logic [31:0] vec(input logic [31:0] base, input int c);
      return {base[31:8], 8'h00} + 32'(c * 32);
   endfunction

   // advance one cycle and drop every strobe
   task automatic tick();
      @(negedge clk);
      dbg_req = 0; norm_req = 0; bret = 0; eret = 0;
      eba_we = 0; deba_we = 0; remap_we = 0; ie_we = 0;
   endtask

   task automatic set_ie(input logic v);
      ie_we = 1; ie_wdata = v; m_ie = v;
      tick();
      check("R11 ie write", 32'(ie_global), 32'(v));
   endtask

   task automatic set_remap(input logic v);
      remap_we = 1; remap_wdata = v; m_remap = v;
      tick();
      check("R5 remap write", 32'(remap_state), 32'(v));
   endtask

   task automatic t_reset();
      check("R1 valid", 32'(redirect_valid), 0);
      check("R1 pc", redirect_pc, 0);
      check("R1 remap", 32'(remap_state), 0);
      check_state("R1");
   endtask

   task automatic t_bases();
      eba_we = 1; base_wdata = 32'h1000_00FF; m_eba = 32'h1000_0000;
      tick();
      deba_we = 1; base_wdata = 32'h2000_005A; m_deba = 32'h2000_0000;
      tick();
   endtask

   task automatic do_norm(input string tag, input int c, input logic [31:0] pc);
      norm_req = 1; norm_cause = 3'(c); req_pc = pc;
      tick();
      m_ea = pc; m_eie = m_ie; m_ie = 0;
      check({tag, " valid"}, 32'(redirect_valid), 1);
      check({tag, " pc"}, redirect_pc, vec(m_remap ? m_deba : m_eba, c));
      check_state(tag);
   endtask

   task automatic do_dbg(input string tag, input logic watch, input logic [31:0] pc);
      dbg_req = 1; dbg_watch = watch; req_pc = pc;
      tick();
      m_ba = pc; m_bie = m_ie; m_ie = 0;
      check({tag, " valid"}, 32'(redirect_valid), 1);
      check({tag, " pc"}, redirect_pc, vec(m_deba, watch ? 3 : 1));
      check_state(tag);
   endtask

   task automatic t_normal_entry();
      set_ie(1);
      do_norm("R2 R7 irq", 6, 32'h0000_0400);
      tick();
      check("R4 one-cycle pulse", 32'(redirect_valid), 0);
      do_norm("R2 scall ie0", 7, 32'h0000_0444);
   endtask

   task automatic t_eret();
      set_ie(1);
      do_norm("R2 dbus", 4, 32'h0000_0500);
      eret = 1;
      tick();
      m_ie = m_eie;
      check("R10 eret valid", 32'(redirect_valid), 1);
      check("R10 eret pc", redirect_pc, m_ea);
      check_state("R10 eret");
   endtask

   task automatic t_remap();
      set_remap(1);
      set_ie(1);
      do_norm("R5 remap ibus", 2, 32'h0000_0800);
      set_remap(0);
      do_norm("R5 no-remap divz", 5, 32'h0000_0804);
   endtask

   task automatic t_debug();
      set_ie(1);
      do_dbg("R3 R6 brkpt", 0, 32'h0000_0900);
      set_remap(1);
      do_dbg("R3 R6 watch remap", 1, 32'h0000_0904);
      set_remap(0);
      bret = 1;
      tick();
      m_ie = m_bie;
      check("R10 bret valid", 32'(redirect_valid), 1);
      check("R10 bret pc", redirect_pc, m_ba);
      check_state("R10 bret");
   endtask

   task automatic t_collision();
      set_ie(1);
      norm_req = 1; norm_cause = 3'd5;
      do_dbg("R8 dbg wins", 1, 32'h0000_0A00);
   endtask

   task automatic t_ignored();
      set_ie(1);
      for (int c = 0; c < 4; c++) begin
         if (c == 2) continue;
         norm_req = 1; norm_cause = 3'(c); req_pc = 32'hDEAD_0000 + 32'(c);
         tick();
         check("R9 ignored valid", 32'(redirect_valid), 0);
         check_state("R9 ignored");
      end
   endtask

   task automatic t_ret_priority();
      set_ie(1);
      eret = 1;
      do_norm("R10 exc beats eret", 6, 32'h0000_0C00);
      bret = 1; eret = 1;
      tick();
      m_ie = m_bie;
      check("R10 bret beats eret pc", redirect_pc, m_ba);
      check_state("R10 bret beats eret");
   endtask

   initial begin
      #(5.0 * 20000);
      n_bad++;
      $display("FAIL watchdog R1: actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      tick();
      t_bases();
      t_normal_entry();
      t_eret();
      t_remap();
      t_debug();
      t_collision();
      t_ignored();
      t_ret_priority();
      tick();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule